// File: doc/BRIEF.md
# Reset and Clock Stabilization Sequencer

This block steps a small microcontroller from reset to normal running. It also guards the choice of the PLL as system clock. A settings reset can come from the external pin or from an internal request, such as a watchdog or software. Once the reset is released, the block times an oscillator-stabilization wait, then holds an operation-reset phase for a fixed number of cycles, and then lets the core run. All counting runs on the oscillator clock.

The length of the stabilization wait depends on what caused the reset. The external pin forces the wait-select register to its shortest setting, so the first wait after a pin reset is always the minimum. An internal reset keeps the value that software programmed.

The PLL can only run while the block is in the running phase. Each time the PLL is enabled, or its multiplier is changed to a different value, a lock timer starts again. Until that timer expires, the PLL is reported as not ready and cannot be chosen as the clock source. When the timer expires, a one-cycle lock-done interrupt is raised. The core keeps running on the oscillator clock while the PLL locks.

Top module: `rst_clk_seq`

## Requirements
- R1: While `rst` is high, `init_rst` is 1, `wsel` is 0, and `pll_on`, `pll_ready`, `lock_irq` and `src_pll` are all 0.
- R2: While `init_pin` is high, the block stays in the settings-reset phase (`init_rst`=1). `wsel` reads 0 from the following cycle on, and writes to it are ignored.
- R3: After a settings reset is released, `osc_wait` is high for exactly 2^(WAIT_BASE + WAIT_STEP*wsel) cycles. The `wsel` codes 0, 1, 2 and 3 give the four lengths in rising order, and code 0 is the minimum.
- R4: The first wait after a pin reset uses code 0, whatever value was programmed before.
- R5: A one-cycle `init_req` puts the block in the settings-reset phase in the next cycle and keeps the programmed `wsel`. The following wait uses that code.
- R6: Each stabilization wait is followed by `op_rst` held high for exactly OPRST_CYC cycles. After that, `running` is 1.
- R7: Writes to `wsel` and `mul` take effect only while `running` is 1. Writes at other times are ignored.
- R8: `pll_on` follows `pll_en` only in the running phase. In the cycle after an internal or pin reset, `pll_on`, `pll_ready` and `src_pll` are all 0.
- R9: `pll_ready` rises exactly 2^LOCK_EXP cycles after `pll_on` rises, and `running` stays 1 during that time. `lock_irq` is a single-cycle pulse in the cycle where `pll_ready` rises.
- R10: Writing a multiplier value that differs from `mul` while the PLL is on drops `pll_ready` in the next cycle and restarts the full lock wait. Writing the same value has no effect.
- R11: `src_pll` is 1 only while `src_req` is 1 and `pll_ready` is 1. A request made while the PLL is not ready leaves the oscillator selected (`src_pll`=0).
- R12: A multiplier change sampled on the same edge where the lock wait would complete wins. No interrupt is raised, `pll_ready` stays 0, and a new full wait begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| init_pin | input | 1 | External settings-reset pin, active high |
| init_req | input | 1 | Internal settings-reset request |
| wsel_wr | input | 1 | Write strobe for the wait-select register |
| wsel_din | input | 2 | New wait-select code |
| pll_en | input | 1 | PLL enable request |
| mul_wr | input | 1 | Write strobe for the multiplier register |
| mul_din | input | MUL_W | New multiplier value |
| src_req | input | 1 | Request to run from the PLL clock |
| init_rst | output | 1 | Settings-reset phase active |
| osc_wait | output | 1 | Oscillator-stabilization wait active |
| op_rst | output | 1 | Operation-reset phase active |
| running | output | 1 | Normal running |
| wsel | output | 2 | Current wait-select code |
| pll_on | output | 1 | PLL enable towards the analog PLL |
| pll_ready | output | 1 | PLL lock wait elapsed |
| lock_irq | output | 1 | One-cycle lock-done interrupt |
| src_pll | output | 1 | 1 selects the PLL clock, 0 the oscillator |
| mul | output | MUL_W | Current multiplier value |

## Verification
Two events can land on the same edge: the lock timer finishing its last count, and a multiplier write that restarts it. The bench enables the PLL and counts cycles from the rise of `pll_on`. It then places a different multiplier value so that it is sampled on exactly the completing edge. Just after that edge, the bench expects `pll_ready` and `lock_irq` to be 0. It then expects a ready rise at twice the lock length, and a total interrupt count that does not include the lost completion.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    PH_INIT  = 2'd0,
    PH_OSCW  = 2'd1,
    PH_OPRST = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;
endpackage

// File: rtl/rcs_phase_fsm.sv
module rcs_phase_fsm
  import rcs_pkg::*;
#(
  parameter int WAIT_BASE = 10,
  parameter int WAIT_STEP = 3,
  parameter int OPRST_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_pin,
  input  logic       init_req,
  input  logic       wsel_wr,
  input  logic [1:0] wsel_din,
  output phase_t     phase,
  output logic [1:0] wsel
);
  localparam int MAX_EXP = WAIT_BASE + 3 * WAIT_STEP;
  localparam int OW      = $clog2(OPRST_CYC + 1);
  localparam int CW      = (MAX_EXP + 1 > OW) ? MAX_EXP + 1 : OW;

  // Last count value for each wait-select code.
  logic [CW-1:0] wait_tab [4];
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < 4; g++) begin : g_wait
    assign wait_tab[g] = CW'((64'd1 << (WAIT_BASE + WAIT_STEP * g)) - 64'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INIT;
      cnt   <= '0;
      wsel  <= '0;
    end else begin
      // The pin forces the shortest wait. An internal reset keeps the code.
      if (init_pin)
        wsel <= '0;
      else if (wsel_wr && phase == PH_RUN)
        wsel <= wsel_din;

      if (init_pin || init_req) begin
        phase <= PH_INIT;
        cnt   <= '0;
      end else begin
        unique case (phase)
          PH_INIT: begin
            phase <= PH_OSCW;
            cnt   <= '0;
          end
          PH_OSCW: begin
            if (cnt == wait_tab[wsel]) begin
              phase <= PH_OPRST;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_OPRST: begin
            if (cnt == CW'(OPRST_CYC - 1)) begin
              phase <= PH_RUN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_RUN: phase <= PH_RUN;
        endcase
      end
    end
  end

  a_r2_pin_clears_sel: assert property (@(posedge clk) disable iff (rst)
    init_pin |=> (wsel == 2'd0));

  a_r7_sel_held_outside_run: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_RUN && !init_pin) |=> $stable(wsel));

  a_r6_run_after_oprst: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> ($past(phase) == PH_RUN || $past(phase) == PH_OPRST));
endmodule

// File: rtl/rcs_pll_lock.sv
module rcs_pll_lock #(
  parameter int LOCK_EXP = 12,
  parameter int MUL_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_ok,
  input  logic             pll_en,
  input  logic             mul_wr,
  input  logic [MUL_W-1:0] mul_din,
  input  logic             src_req,
  output logic             pll_on,
  output logic             pll_ready,
  output logic             lock_irq,
  output logic             src_pll,
  output logic [MUL_W-1:0] mul
);
  localparam int LW = LOCK_EXP + 1;
  localparam logic [LW-1:0] LOCK_LAST = LW'((64'd1 << LOCK_EXP) - 64'd1);

  logic          locking, locking_n, ready_n, irq_n, on_n, mul_chg, restart;
  logic [LW-1:0] lcnt, lcnt_n;

  assign on_n    = run_ok & pll_en;
  assign mul_chg = run_ok & mul_wr & (mul_din != mul);
  assign restart = on_n & (~pll_on | mul_chg);

  always_comb begin
    locking_n = locking;
    lcnt_n    = lcnt;
    ready_n   = pll_ready;
    irq_n     = 1'b0;
    if (!on_n) begin
      locking_n = 1'b0;
      lcnt_n    = '0;
      ready_n   = 1'b0;
    end else if (restart) begin
      // A restart outranks a completion on the same edge.
      locking_n = 1'b1;
      lcnt_n    = '0;
      ready_n   = 1'b0;
    end else if (locking) begin
      if (lcnt == LOCK_LAST) begin
        locking_n = 1'b0;
        ready_n   = 1'b1;
        irq_n     = 1'b1;
      end else begin
        lcnt_n = lcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_on    <= 1'b0;
      locking   <= 1'b0;
      lcnt      <= '0;
      pll_ready <= 1'b0;
      lock_irq  <= 1'b0;
      src_pll   <= 1'b0;
      mul       <= '0;
    end else begin
      pll_on    <= on_n;
      locking   <= locking_n;
      lcnt      <= lcnt_n;
      pll_ready <= ready_n;
      lock_irq  <= irq_n;
      src_pll   <= src_req & ready_n;
      if (run_ok && mul_wr)
        mul <= mul_din;
    end
  end

  a_r11_src_needs_ready: assert property (@(posedge clk) disable iff (rst)
    src_pll |-> pll_ready);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    lock_irq |=> !lock_irq);

  a_r9_irq_on_ready_rise: assert property (@(posedge clk) disable iff (rst)
    lock_irq |-> (pll_ready && !$past(pll_ready)));

  a_r10_newmul_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (mul_chg && pll_on) |=> !pll_ready);
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import rcs_pkg::*;
#(
  parameter int WAIT_BASE = 10,
  parameter int WAIT_STEP = 3,
  parameter int OPRST_CYC = 4,
  parameter int LOCK_EXP  = 12,
  parameter int MUL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_pin,
  input  logic             init_req,
  input  logic             wsel_wr,
  input  logic [1:0]       wsel_din,
  input  logic             pll_en,
  input  logic             mul_wr,
  input  logic [MUL_W-1:0] mul_din,
  input  logic             src_req,
  output logic             init_rst,
  output logic             osc_wait,
  output logic             op_rst,
  output logic             running,
  output logic [1:0]       wsel,
  output logic             pll_on,
  output logic             pll_ready,
  output logic             lock_irq,
  output logic             src_pll,
  output logic [MUL_W-1:0] mul
);
  phase_t phase;
  logic   run_ok;

  rcs_phase_fsm #(
    .WAIT_BASE(WAIT_BASE),
    .WAIT_STEP(WAIT_STEP),
    .OPRST_CYC(OPRST_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .init_pin(init_pin), .init_req(init_req),
    .wsel_wr(wsel_wr), .wsel_din(wsel_din), .phase(phase), .wsel(wsel)
  );

  // The PLL drops on the same edge that a settings reset takes effect.
  assign run_ok = (phase == PH_RUN) & ~init_pin & ~init_req;

  rcs_pll_lock #(
    .LOCK_EXP(LOCK_EXP),
    .MUL_W(MUL_W)
  ) u_pll (
    .clk(clk), .rst(rst), .run_ok(run_ok), .pll_en(pll_en),
    .mul_wr(mul_wr), .mul_din(mul_din), .src_req(src_req),
    .pll_on(pll_on), .pll_ready(pll_ready), .lock_irq(lock_irq),
    .src_pll(src_pll), .mul(mul)
  );

  assign init_rst = (phase == PH_INIT);
  assign osc_wait = (phase == PH_OSCW);
  assign op_rst   = (phase == PH_OPRST);
  assign running  = (phase == PH_RUN);

  a_r8_pll_off_unless_run: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!pll_on && !pll_ready && !src_pll));

  a_r3_wait_follows_init: assert property (@(posedge clk) disable iff (rst)
    (osc_wait && !$past(osc_wait)) |-> $past(init_rst));
endmodule

// File: tb/rst_clk_seq_tb.sv
module rst_clk_seq_tb;
  localparam int WB = 4, WS = 2, OPC = 4, LE = 5, MW = 4;
  localparam int LOCK = 1 << LE;

  logic clk = 1'b0, rst = 1'b1, init_pin = 1'b0, init_req = 1'b0;
  logic wsel_wr = 1'b0, pll_en = 1'b0, mul_wr = 1'b0, src_req = 1'b0;
  logic [1:0] wsel_din = '0;
  logic [MW-1:0] mul_din = '0;
  logic init_rst, osc_wait, op_rst, running, pll_on, pll_ready, lock_irq, src_pll;
  logic [1:0] wsel;
  logic [MW-1:0] mul;

  int total = 0, bad = 0;
  int exp_osc[$];
  int exp_lock[$];
  int osc_len = 0, op_len = 0, lk_len = 0, irq_cnt = 0;
  logic prev_ready = 1'b0;

  always #5 clk = ~clk;

  rst_clk_seq #(.WAIT_BASE(WB), .WAIT_STEP(WS), .OPRST_CYC(OPC),
                .LOCK_EXP(LE), .MUL_W(MW)) u_dut (
    .clk(clk), .rst(rst), .init_pin(init_pin), .init_req(init_req),
    .wsel_wr(wsel_wr), .wsel_din(wsel_din), .pll_en(pll_en),
    .mul_wr(mul_wr), .mul_din(mul_din), .src_req(src_req),
    .init_rst(init_rst), .osc_wait(osc_wait), .op_rst(op_rst),
    .running(running), .wsel(wsel), .pll_on(pll_on), .pll_ready(pll_ready),
    .lock_irq(lock_irq), .src_pll(src_pll), .mul(mul)
  );

  task automatic chk(input logic ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int wlen(input int code);
    return 1 << (WB + WS * code);
  endfunction

  // Monitor: measures wait, op-reset and lock windows, and compares them with the queues.
  always @(negedge clk) begin
    if (!rst) begin
      if (osc_wait) osc_len++;
      else if (osc_len > 0) begin
        if (exp_osc.size() == 0) chk(1'b0, "R3 unexpected wait", osc_len, 0);
        else begin
          int e;
          e = exp_osc.pop_front();
          chk(osc_len == e, "R3/R4/R5 wait length", osc_len, e);
        end
        osc_len = 0;
      end
      if (op_rst) op_len++;
      else if (op_len > 0) begin
        chk(op_len == OPC && running, "R6 op reset length", op_len, OPC);
        op_len = 0;
      end
      if (!pll_on) lk_len = 0;
      else if (!pll_ready) lk_len++;
      else if (!prev_ready) begin
        chk(lock_irq == 1'b1, "R9 irq with ready rise", int'(lock_irq), 1);
        if (exp_lock.size() == 0) chk(1'b0, "R9 unexpected lock", lk_len, 0);
        else begin
          int e;
          e = exp_lock.pop_front();
          chk(lk_len == e, "R9/R10/R12 lock length", lk_len, e);
        end
        lk_len = 0;
      end
      if (lock_irq) irq_cnt++;
      prev_ready = pll_ready;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_run();
    while (!running) @(negedge clk);
  endtask

  task automatic int_reset(input int code);
    exp_osc.push_back(wlen(code));
    init_req = 1'b1;
    tick(1);
    init_req = 1'b0;
    chk(init_rst == 1'b1, "R5 init state", int'(init_rst), 1);
    chk(wsel == 2'(code), "R5 sel kept", int'(wsel), code);
    wait_run();
  endtask

  task automatic set_sel(input int code);
    wsel_din = 2'(code); wsel_wr = 1'b1;
    tick(1);
    wsel_wr = 1'b0;
  endtask

  initial begin
    tick(2);
    chk(init_rst && wsel == 2'd0 && !pll_on && !pll_ready && !lock_irq && !src_pll,
        "R1 reset state", int'(init_rst), 1);
    init_pin = 1'b1;
    rst = 1'b0;
    wsel_din = 2'd3; wsel_wr = 1'b1;
    mul_din = 4'd7; mul_wr = 1'b1;
    tick(1);
    wsel_wr = 1'b0; mul_wr = 1'b0;
    tick(1);
    chk(wsel == 2'd0 && init_rst, "R2 pin forces sel", int'(wsel), 0);
    chk(mul == '0, "R7 mul write ignored", int'(mul), 0);
    exp_osc.push_back(wlen(0));
    init_pin = 1'b0;
    wait_run();

    set_sel(2);
    chk(wsel == 2'd2, "R7 sel write in run", int'(wsel), 2);
    int_reset(2);
    set_sel(3);
    int_reset(3);

    set_sel(1);
    init_pin = 1'b1;
    tick(2);
    chk(wsel == 2'd0 && init_rst, "R4 pin clears sel", int'(wsel), 0);
    exp_osc.push_back(wlen(0));
    init_pin = 1'b0;
    wait_run();
    set_sel(1);
    int_reset(1);

    src_req = 1'b1;
    tick(2);
    chk(src_pll == 1'b0, "R11 refused while off", int'(src_pll), 0);
    exp_lock.push_back(LOCK);
    pll_en = 1'b1;
    tick(1);
    chk(pll_on == 1'b1, "R8 pll on in run", int'(pll_on), 1);
    tick(LOCK / 2);
    chk(src_pll == 1'b0 && running, "R11 refused while locking", int'(src_pll), 0);
    while (!pll_ready) @(negedge clk);
    chk(src_pll == 1'b1, "R11 select after lock", int'(src_pll), 1);

    mul_din = '0; mul_wr = 1'b1;
    tick(1);
    mul_wr = 1'b0;
    chk(pll_ready == 1'b1, "R10 equal mul keeps ready", int'(pll_ready), 1);
    exp_lock.push_back(LOCK);
    mul_din = 4'd5; mul_wr = 1'b1;
    tick(1);
    mul_wr = 1'b0;
    chk(!pll_ready && !src_pll && mul == 4'd5, "R10 new mul drops ready", int'(pll_ready), 0);
    while (!pll_ready) @(negedge clk);

    // R12: the multiplier write lands on the completing edge.
    pll_en = 1'b0;
    tick(1);
    chk(pll_on == 1'b0, "R8 pll off", int'(pll_on), 0);
    exp_lock.push_back(2 * LOCK);
    pll_en = 1'b1;
    tick(1);
    tick(LOCK - 1);
    mul_din = 4'd9; mul_wr = 1'b1;
    tick(1);
    mul_wr = 1'b0;
    chk(!pll_ready && !lock_irq, "R12 restart wins", int'(pll_ready) + int'(lock_irq), 0);
    while (!pll_ready) @(negedge clk);
    tick(1);
    chk(irq_cnt == 3, "R9 irq count", irq_cnt, 3);

    init_req = 1'b1;
    tick(1);
    init_req = 1'b0;
    chk(!pll_on && !pll_ready && !src_pll, "R8 off after reset", int'(pll_on), 0);
    exp_osc.push_back(wlen(1));
    wait_run();
    tick(2);
    chk(exp_osc.size() == 0 && exp_lock.size() == 0, "R3 queues drained",
        exp_osc.size() + exp_lock.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule